// File: doc/BRIEF.md
# Byte-Bus Multiply/Divide Coprocessor

This block is an arithmetic helper that hangs off an 8-bit processor bus. Software fills six byte-wide operand/result registers (MD0 to MD5), then pulses a start strobe with a 2-bit opcode. The block works through the calculation by itself over a fixed number of clock cycles while the processor carries on with other work. It then writes the result back into the same six registers, where software reads it one byte at a time.

Three operations exist: unsigned 32-by-16 division, unsigned 16-by-16 division and unsigned 16-by-16 multiplication. Division runs a restoring shift-subtract loop that retires two quotient bits per cycle. Multiplication runs a shift-add loop that takes two multiplier bits per cycle. Each operation is padded so that its run length never varies. A status byte shows whether the block is busy, whether it has finished, and whether the last division had a zero divisor. A separate output stays high from completion until software reads the byte that closes the result.

Top module: `md_coproc`

## Requirements
- R1: After synchronous reset, `status` is 0x40 (finish bit 6 set, error bit 1 and busy bit 0 clear), `busy` and `readout_pending` are 0, and MD0 to MD5 all read 0.
- R2: When not busy, a bus write to address 0 to 5 stores the byte. A bus read presents the addressed byte on `bus_rdata` after the clock edge that samples `bus_rd`. Addresses 6 and 7 read 0 and ignore writes. Writes made while busy are ignored.
- R3: Opcode 00 divides the dividend MD3:MD2:MD1:MD0 (MD0 least significant) by the divisor MD5:MD4. The quotient goes to MD3..MD0 and the remainder to MD5:MD4. The finish bit rises on the 17th rising edge after the edge that accepts the start.
- R4: Opcode 01 divides MD1:MD0 by MD5:MD4. The quotient goes to MD1:MD0, MD3 and MD2 become 0, and the remainder goes to MD5:MD4. Completion comes 9 edges after acceptance.
- R5: Opcode 10 multiplies MD1:MD0 by MD5:MD4. The 32-bit product goes to MD3..MD0 and MD5 and MD4 become 0. Completion comes 11 edges after acceptance.
- R6: The edge that accepts a start clears the finish bit and raises `busy`. `busy` stays high until the completion edge, which clears `busy` and sets the finish bit again.
- R7: A start strobe is ignored while busy, and a start carrying opcode 11 is ignored at any time.
- R8: On division by a zero divisor, error bit 1 of `status` is set at completion. The quotient is all ones in its own width (32 bits for opcode 00, 16 bits for opcode 01), and the remainder equals the low 16 bits of the dividend. The error bit is cleared by the next accepted start and by any division with a nonzero divisor.
- R9: `readout_pending` rises at completion. Only a bus read of MD5 (after a division) or MD3 (after a multiplication) clears it. Reads of other addresses leave it set, and the next accepted start also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address (0 to 5 = MD0 to MD5) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| start | input | 1 | One-cycle start strobe |
| op | input | 2 | Opcode: 00 div 32/16, 01 div 16/16, 10 multiply, 11 none |
| busy | output | 1 | Calculation in progress |
| status | output | 8 | Bit 6 finish, bit 1 divide-by-zero, bit 0 busy |
| readout_pending | output | 1 | Result not yet closed by the final read |

## Verification
The sweep drives operands at the extremes: a divisor of one, a divisor of 0xFFFF, a dividend below the divisor, an all-ones dividend and a zero divisor. Among these, an off-by-one in the quotient-bit shift or a missed restore step corrupts the quotient or the remainder, and the zero-divisor override shows whether it picks the correct width. The bench times every run to the exact edge, so a counter that is one short or one long, or that fails to pad multiplication to its length, moves the finish bit and is caught. It also writes into MD0 and pulses start in the middle of a run. A block that accepts either one corrupts the result or stretches the run. Read order is checked by reading every other byte first, so a block that clears `readout_pending` on the wrong address is exposed.

// File: rtl/md_pkg.sv
package md_pkg;
  typedef enum logic [1:0] {
    OP_DIV32 = 2'b00,
    OP_DIV16 = 2'b01,
    OP_MUL   = 2'b10,
    OP_NONE  = 2'b11
  } md_op_e;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_ERR_BIT  = 1;
  localparam int STAT_FIN_BIT  = 6;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/md_regfile.sv
module md_regfile #(
  parameter int BYTE_W   = 8,
  parameter int NUM_REGS = 6,
  parameter int ADDR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [BYTE_W-1:0]          rdata,
  input  logic                       ld_en,
  input  logic [NUM_REGS*BYTE_W-1:0] ld_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  logic [BYTE_W-1:0] mem [NUM_REGS];
  logic              in_range;

  assign in_range = (addr < ADDR_W'(NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
    end else if (ld_en) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= ld_data[i*BYTE_W +: BYTE_W];
    end else if (wr_en && in_range) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_en)  rdata <= in_range ? mem[addr] : '0;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign regs_flat[g*BYTE_W +: BYTE_W] = mem[g];
  end
endmodule

// File: rtl/md_divider.sv
module md_divider #(
  parameter int OPW        = 16,
  parameter int RADIX_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             wide_i,
  input  logic [2*OPW-1:0] dividend,
  input  logic [OPW-1:0]   divisor,
  output logic [2*OPW-1:0] quot_o,
  output logic [OPW-1:0]   rem_o,
  output logic             dz_o
);
  logic [OPW-1:0]   rem_q, dv_q, dlo_q;
  logic [2*OPW-1:0] q_q;
  logic             wide_q;
  logic [3*OPW-1:0] nxt;

  function automatic logic [3*OPW-1:0] div_iter(input logic [OPW-1:0] r,
                                                input logic [2*OPW-1:0] q,
                                                input logic [OPW-1:0] d);
    logic [OPW:0]     t;
    logic [OPW-1:0]   rr;
    logic [2*OPW-1:0] qq;
    rr = r;
    qq = q;
    for (int i = 0; i < RADIX_BITS; i++) begin
      t  = {rr, qq[2*OPW-1]};
      qq = {qq[2*OPW-2:0], 1'b0};
      if (t >= {1'b0, d}) begin
        t     = t - {1'b0, d};
        qq[0] = 1'b1;
      end
      rr = t[OPW-1:0];
    end
    return {rr, qq};
  endfunction

  assign nxt = div_iter(rem_q, q_q, dv_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      q_q    <= '0;
      dv_q   <= '0;
      dlo_q  <= '0;
      wide_q <= 1'b0;
    end else if (load) begin
      rem_q  <= '0;
      q_q    <= wide_i ? dividend : {dividend[OPW-1:0], {OPW{1'b0}}};
      dv_q   <= divisor;
      dlo_q  <= dividend[OPW-1:0];
      wide_q <= wide_i;
    end else if (step) begin
      rem_q <= nxt[3*OPW-1:2*OPW];
      q_q   <= nxt[2*OPW-1:0];
    end
  end

  assign dz_o = (dv_q == '0);

  always_comb begin
    if (dz_o) begin
      quot_o = wide_q ? {2*OPW{1'b1}} : {{OPW{1'b0}}, {OPW{1'b1}}};
      rem_o  = dlo_q;
    end else begin
      quot_o = wide_q ? q_q : {{OPW{1'b0}}, q_q[OPW-1:0]};
      rem_o  = rem_q;
    end
  end
endmodule

// File: rtl/md_multiplier.sv
module md_multiplier #(
  parameter int OPW        = 16,
  parameter int RADIX_BITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [OPW-1:0]   mcand,
  input  logic [OPW-1:0]   mplier,
  output logic [2*OPW-1:0] prod_o
);
  logic [2*OPW-1:0] p_q;
  logic [OPW-1:0]   mc_q;

  function automatic logic [2*OPW-1:0] mul_iter(input logic [2*OPW-1:0] p,
                                                input logic [OPW-1:0] m);
    logic [OPW:0]     s;
    logic [2*OPW-1:0] pp;
    pp = p;
    for (int i = 0; i < RADIX_BITS; i++) begin
      s  = {1'b0, pp[2*OPW-1:OPW]} + (pp[0] ? {1'b0, m} : {(OPW+1){1'b0}});
      pp = {s, pp[OPW-1:1]};
    end
    return pp;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q  <= '0;
      mc_q <= '0;
    end else if (load) begin
      p_q  <= {{OPW{1'b0}}, mplier};
      mc_q <= mcand;
    end else if (step) begin
      p_q <= mul_iter(p_q, mc_q);
    end
  end

  assign prod_o = p_q;
endmodule

// File: rtl/md_sequencer.sv
module md_sequencer
  import md_pkg::*;
#(
  parameter int OPW        = 16,
  parameter int RADIX_BITS = 2,
  parameter int CYC_DIV32  = 17,
  parameter int CYC_DIV16  = 9,
  parameter int CYC_MUL    = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] op,
  input  logic       div_zero,
  input  logic       rd_last,
  output logic       load,
  output logic       step,
  output logic       done,
  output md_op_e     cur_op,
  output logic       busy,
  output logic       fin,
  output logic       err,
  output logic       pending
);
  localparam int MAXC   = max3(CYC_DIV32, CYC_DIV16, CYC_MUL);
  localparam int CNT_W  = $clog2(MAXC + 1);
  localparam int STEP_W = (2 * OPW) / RADIX_BITS;
  localparam int STEP_N = OPW / RADIX_BITS;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt, step_lim;

  always_comb begin
    unique case (cur_op)
      OP_DIV32: begin last_cnt = CNT_W'(CYC_DIV32 - 1); step_lim = CNT_W'(STEP_W); end
      OP_DIV16: begin last_cnt = CNT_W'(CYC_DIV16 - 1); step_lim = CNT_W'(STEP_N); end
      default:  begin last_cnt = CNT_W'(CYC_MUL - 1);   step_lim = CNT_W'(STEP_N); end
    endcase
  end

  assign load = start && !busy && (op != OP_NONE);
  assign done = busy && (cnt == last_cnt);
  assign step = busy && (cnt < step_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      fin     <= 1'b1;
      err     <= 1'b0;
      pending <= 1'b0;
      cur_op  <= OP_DIV32;
    end else if (load) begin
      busy    <= 1'b1;
      cnt     <= '0;
      fin     <= 1'b0;
      err     <= 1'b0;
      pending <= 1'b0;
      cur_op  <= md_op_e'(op);
    end else if (busy) begin
      if (done) begin
        busy    <= 1'b0;
        fin     <= 1'b1;
        pending <= 1'b1;
        err     <= div_zero && (cur_op != OP_MUL);
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (rd_last && pending) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/md_coproc.sv
module md_coproc
  import md_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int RADIX_BITS = 2,
  parameter int CYC_DIV32  = 17,
  parameter int CYC_DIV16  = 9,
  parameter int CYC_MUL    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              start,
  input  logic [1:0]        op,
  output logic              busy,
  output logic [7:0]        status,
  output logic              readout_pending
);
  localparam int NUM_REGS = 6;
  localparam int ADDR_W   = 3;
  localparam int OPW      = 2 * BYTE_W;
  localparam int FLAT_W   = NUM_REGS * BYTE_W;
  localparam logic [ADDR_W-1:0] LAST_DIV = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] LAST_MUL = ADDR_W'(3);

  logic [FLAT_W-1:0] regs_flat, ld_data;
  logic              load, step, done, fin, err, dz, rd_last;
  md_op_e            cur_op;
  logic [2*OPW-1:0]  quot, prod;
  logic [OPW-1:0]    rem;

  assign rd_last = bus_rd && (bus_addr == ((cur_op == OP_MUL) ? LAST_MUL : LAST_DIV));

  md_sequencer #(
    .OPW(OPW), .RADIX_BITS(RADIX_BITS),
    .CYC_DIV32(CYC_DIV32), .CYC_DIV16(CYC_DIV16), .CYC_MUL(CYC_MUL)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .div_zero(dz), .rd_last(rd_last),
    .load(load), .step(step), .done(done), .cur_op(cur_op), .busy(busy),
    .fin(fin), .err(err), .pending(readout_pending)
  );

  md_divider #(.OPW(OPW), .RADIX_BITS(RADIX_BITS)) u_div (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .wide_i(op == OP_DIV32),
    .dividend(regs_flat[2*OPW-1:0]),
    .divisor(regs_flat[FLAT_W-1 -: OPW]),
    .quot_o(quot), .rem_o(rem), .dz_o(dz)
  );

  md_multiplier #(.OPW(OPW), .RADIX_BITS(RADIX_BITS)) u_mul (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .mcand(regs_flat[OPW-1:0]),
    .mplier(regs_flat[FLAT_W-1 -: OPW]),
    .prod_o(prod)
  );

  assign ld_data = (cur_op == OP_MUL) ? {{OPW{1'b0}}, prod} : {rem, quot};

  md_regfile #(.BYTE_W(BYTE_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst(rst), .wr_en(bus_wr && !busy), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .ld_en(done), .ld_data(ld_data), .regs_flat(regs_flat)
  );

  always_comb begin
    status                = '0;
    status[STAT_FIN_BIT]  = fin;
    status[STAT_ERR_BIT]  = err;
    status[STAT_BUSY_BIT] = busy;
  end
endmodule

// File: rtl/md_checker.sv
module md_checker #(
  parameter int CYC_DIV32 = 17,
  parameter int CYC_DIV16 = 9,
  parameter int CYC_MUL   = 11
) (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] op,
  input logic       busy,
  input logic [7:0] status,
  input logic       readout_pending
);
  logic       accept;
  logic [1:0] op_q;
  int         run_len;
  int         exp_len;

  assign accept  = start && !busy && (op != 2'b11);
  assign exp_len = (op_q == 2'b00) ? CYC_DIV32 : (op_q == 2'b01) ? CYC_DIV16 : CYC_MUL;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= 2'b00;
      run_len <= 0;
    end else if (accept) begin
      op_q    <= op;
      run_len <= 0;
    end else if (busy) begin
      run_len <= run_len + 1;
    end
  end

  // R3, R4 and R5: every run lasts exactly the length of its opcode
  p_cycles_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == exp_len));

  p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !status[6] && !readout_pending));

  p_flag_not_busy_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !status[6]);

  p_no_op_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'b11) |=> !busy);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
    status[1] |-> (!busy && op_q != 2'b10));

  p_pending_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (readout_pending && status[6]));
endmodule

bind md_coproc md_checker #(
  .CYC_DIV32(CYC_DIV32), .CYC_DIV16(CYC_DIV16), .CYC_MUL(CYC_MUL)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .busy(busy),
  .status(status), .readout_pending(readout_pending)
);

// File: tb/sim_md_coproc.sv
module sim_md_coproc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, start = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] op = 2'b11;
  logic [7:0] bus_rdata, status;
  logic       busy, readout_pending;

  int checks = 0;
  int failures = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #5 clk = ~clk;

  md_coproc u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .start(start), .op(op),
    .busy(busy), .status(status), .readout_pending(readout_pending)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic next_rand(output logic [31:0] v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = seed;
  endtask

  // Launch, time the run to the edge; inject = busy-time write and restart (R2, R7)
  task automatic run(input logic [1:0] o, input int n, input bit inject, input string req);
    start = 1'b1; op = o;
    @(negedge clk);
    start = 1'b0; op = 2'b11;
    chk("R6 busy and finish bit after accept", {busy, status[6]}, 2'b10);
    for (int j = 1; j < n; j++) begin
      if (inject && j == 3) begin
        bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h5A;
        start = 1'b1; op = 2'b10;
      end
      @(negedge clk);
      bus_wr = 1'b0; start = 1'b0; op = 2'b11;
    end
    chk({req, " still busy one edge before end"}, busy, 1'b1);
    @(negedge clk);
    chk({req, " completion edge busy/finish"}, {busy, status[6]}, 2'b01);
  endtask

  task automatic do_op(input logic [1:0] o, input logic [31:0] a, input logic [15:0] b,
                       input bit inject);
    logic [47:0] exp_v, got;
    logic [7:0]  d;
    logic        exp_err;
    int          n;
    string       req;
    logic [2:0]  last;
    exp_err = 1'b0;
    case (o)
      2'b00: begin
        req = "R3"; n = 17; last = 3'd5;
        if (b == 0) begin exp_v = {a[15:0], 32'hFFFF_FFFF}; exp_err = 1'b1; end
        else exp_v = {16'(a % {16'd0, b}), a / {16'd0, b}};
      end
      2'b01: begin
        req = "R4"; n = 9; last = 3'd5;
        if (b == 0) begin exp_v = {a[15:0], 16'h0000, 16'hFFFF}; exp_err = 1'b1; end
        else exp_v = {a[15:0] % b, 16'h0000, a[15:0] / b};
      end
      default: begin
        req = "R5"; n = 11; last = 3'd3;
        exp_v = {16'h0000, {16'd0, a[15:0]} * {16'd0, b}};
      end
    endcase
    wr(3'd0, a[7:0]); wr(3'd1, a[15:8]); wr(3'd2, a[23:16]); wr(3'd3, a[31:24]);
    wr(3'd4, b[7:0]); wr(3'd5, b[15:8]);
    run(o, n, inject, req);
    got = '0;
    for (int r = 0; r < 6; r++) begin
      if (r[2:0] != last) begin
        rd(r[2:0], d);
        got[r*8 +: 8] = d;
      end
    end
    chk("R9 pending survives reads of other bytes", readout_pending, 1'b1);
    rd(last, d);
    got[last*8 +: 8] = d;
    chk("R9 final read closes result", readout_pending, 1'b0);
    chk(b == 0 && o != 2'b10 ? "R8 zero-divisor result" : req, got, exp_v);
    chk("R8 error bit", status[1], exp_err);
  endtask

  initial begin
    logic [7:0]  d;
    logic [31:0] a, b;
    logic [31:0] dv [8] = '{32'hFFFF_FFFF, 32'h0000_0005, 32'h1234_5678, 32'h0000_FFFF,
                             32'h8000_0000, 32'h0000_0000, 32'h7FFF_0001, 32'h0001_0000};
    logic [15:0] ds [8] = '{16'h0001, 16'h0007, 16'h0000, 16'hFFFF,
                             16'h8000, 16'h0003, 16'h00FF, 16'h0002};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 status", status, 8'h40);
    chk("R1 busy/pending", {busy, readout_pending}, 2'b00);
    for (int r = 0; r < 6; r++) begin
      rd(r[2:0], d);
      chk("R1 register cleared", d, 8'h00);
    end
    // R2 plain access
    wr(3'd2, 8'hA5); rd(3'd2, d); chk("R2 write/read MD2", d, 8'hA5);
    wr(3'd6, 8'h3C); rd(3'd6, d); chk("R2 unused address reads zero", d, 8'h00);
    rd(3'd7, d); chk("R2 address 7 reads zero", d, 8'h00);
    // R7 opcode 11 ignored
    start = 1'b1; op = 2'b11; @(negedge clk); start = 1'b0;
    chk("R7 opcode 11 ignored", {busy, status}, {1'b0, 8'h40});
    // R2/R7 busy-time write and restart ignored, checked through result and timing
    do_op(2'b00, 32'hDEAD_BEEF, 16'h1234, 1'b1);
    do_op(2'b01, 32'h0000_9999, 16'h0033, 1'b1);
    // corner sweep
    for (int i = 0; i < 8; i++) begin
      for (int o = 0; o < 3; o++) do_op(o[1:0], dv[i], ds[i], 1'b0);
      do_op(2'b00, dv[i], ds[(i+3)%8], 1'b0);
    end
    // pseudo-random sweep
    for (int i = 0; i < 40; i++) begin
      next_rand(a); next_rand(b);
      if (i % 4 == 1) b = b >> 20;
      for (int o = 0; o < 3; o++) do_op(o[1:0], a, b[15:0], 1'b0);
    end
    // R9 next start clears pending without the final read; R8 error clears on start
    do_op(2'b01, 32'h0000_0010, 16'h0000, 1'b0);
    chk("R8 error held while idle", status[1], 1'b1);
    wr(3'd4, 8'h02); wr(3'd5, 8'h00);
    start = 1'b1; op = 2'b01; @(negedge clk); start = 1'b0; op = 2'b11;
    chk("R8 error cleared by accepted start", status[1], 1'b0);
    repeat (10) @(negedge clk);
    chk("R9 pending set after run", readout_pending, 1'b1);
    rd(3'd3, d);
    chk("R9 MD3 read does not close a division", readout_pending, 1'b1);
    start = 1'b1; op = 2'b10; @(negedge clk); start = 1'b0; op = 2'b11;
    chk("R9 accepted start clears pending", readout_pending, 1'b0);
    repeat (12) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule